// File: doc/BRIEF.md
# Two-Context Switch-on-Miss Issue Selector

This block sits at the front of a single-issue core that keeps two hardware thread contexts. Each context owns a program counter and a bank of architectural registers; the adders, functional units and caches behind them are shared. Software sees the two contexts as two separate processors, numbered 0 and 1. The block decides, every cycle, which context may issue. It hands the fetch stage that context's PC and tells the register file which bank to use.

The running context keeps issuing until it takes a cache miss. The next cycle the block moves issue to the other context, with no context save or restore, because both contexts are held in hardware at all times. A context that is waiting on a miss cannot be picked again until its return event arrives. When neither context can run, issue stops and an idle flag is raised. When issue starts again after an idle stretch and both contexts are ready, the block picks the context that did not issue last. The shared datapath sends PC updates through the block, and each update lands only in the PC of the context that is issuing.

Top module: `mt_thread_sel`

## Requirements
- R1: While reset is held and right after it is released, with both contexts enabled, `sel_tid` is 0, `issue_vld` is 1 and `sel_pc` equals parameter `RESET_PC0`. The PC of context 1 starts at `RESET_PC1`.
- R2: `sel_tid` is 0 or 1, naming the issuing context. `rf_bank_sel` always equals `sel_tid`, and `sel_pc` is the PC held for `sel_tid`.
- R3: A miss (`miss_vld`=1) tagged with the issuing context moves issue away from it. In the cycle after the miss, that context does not issue, and the other context issues if it is enabled and not waiting.
- R4: A context is marked waiting from the cycle after its miss. It stays unselectable until the cycle after `fill_vld[t]` is seen for it.
- R5: When no context is both enabled and not waiting, `issue_vld` is 0 and `idle` is 1 in the same cycle.
- R6: If the previous cycle was idle and both contexts are ready, the context other than the one that issued last is selected.
- R7: While the issuing context stays ready, it keeps issuing, whether or not the other context is ready.
- R8: With `pc_wr_en`=1 in an issuing cycle, `pc_wr_data` is written only into the PC of `sel_tid` and is visible from the next cycle. `pc_wr_en` is ignored while idle.
- R9: A context with `thr_en[t]`=0 is never selected. The effect is immediate, within the same cycle.
- R10: If a miss and a return event for the same context arrive in one cycle, the miss wins and the context is left waiting.
- R11: A return event for a context that is not waiting changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_en | input | 2 | Per-context enable; bit t is context t |
| miss_vld | input | 1 | Cache miss reported this cycle |
| miss_tid | input | 1 | Context that took the miss |
| fill_vld | input | 2 | Per-context miss-return event |
| pc_wr_en | input | 1 | PC update from the datapath |
| pc_wr_data | input | PC_W | New PC value for the issuing context |
| issue_vld | output | 1 | A context issues this cycle |
| idle | output | 1 | No context can issue |
| sel_tid | output | 1 | Selected context number |
| rf_bank_sel | output | 1 | Register bank select |
| sel_pc | output | PC_W | PC of the selected context, for fetch |

## Verification
The switch property assumes that a miss is reported only for the context that issued in that cycle. Return events are expected mostly for contexts that are waiting. The random stimulus follows both assumptions: it raises `miss_vld` only with the bench's predicted issuing context as the tag, and it mostly sends return events to contexts the bench model marks as waiting. A few stray returns and one miss raised during idle are driven on purpose, and only in directed steps whose expected results the properties still allow. Enables drop only briefly, so that every interleaving is reached.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;
  localparam int NTHR = 2;

  typedef struct packed {
    logic vld;
    logic tid;
  } pick_t;

  // Selection rule: keep the running context while ready, else the other one,
  // else the last one, else nothing.
  function automatic pick_t pick_fn(input logic [NTHR-1:0] rdy,
                                    input logic last, input logic run);
    pick_t p;
    p.tid = last;
    p.vld = 1'b0;
    if (run && rdy[last]) begin
      p.vld = 1'b1;
    end else if (rdy[!last]) begin
      p.vld = 1'b1;
      p.tid = !last;
    end else if (rdy[last]) begin
      p.vld = 1'b1;
    end
    return p;
  endfunction
endpackage

// File: rtl/thr_wait_slot.sv
module thr_wait_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic miss_hit,
  input  logic fill,
  output logic waiting_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)        waiting_o <= 1'b0;
    else if (miss_hit) waiting_o <= 1'b1;
    else if (fill)     waiting_o <= 1'b0;
  end

  // R10
  miss_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_hit |=> waiting_o);
endmodule

// File: rtl/thr_pc_slot.sv
module thr_pc_slot #(
  parameter int          PC_W   = 32,
  parameter logic [31:0] RST_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [PC_W-1:0] wdata,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)  pc_o <= RST_PC[PC_W-1:0];
    else if (wr) pc_o <= wdata;
  end
endmodule

// File: rtl/thr_pick.sv
module thr_pick
  import thr_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] rdy,
  output logic            vld_o,
  output logic            tid_o
);
  logic  last_q, run_q;
  pick_t pk;

  always_comb pk = pick_fn(rdy, last_q, run_q);
  assign vld_o = pk.vld;
  assign tid_o = pk.tid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      run_q  <= 1'b1;
    end else begin
      run_q <= pk.vld;
      if (pk.vld) last_q <= pk.tid;
    end
  end

  // R6
  rr_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && rdy == 2'b11) |-> (vld_o && tid_o != last_q));
endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel
  import thr_sel_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter logic [31:0] RESET_PC0 = 32'h0000_1000,
  parameter logic [31:0] RESET_PC1 = 32'h0000_2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      thr_en,
  input  logic            miss_vld,
  input  logic            miss_tid,
  input  logic [1:0]      fill_vld,
  input  logic            pc_wr_en,
  input  logic [PC_W-1:0] pc_wr_data,
  output logic            issue_vld,
  output logic            idle,
  output logic            sel_tid,
  output logic            rf_bank_sel,
  output logic [PC_W-1:0] sel_pc
);
  logic [NTHR-1:0] wait_vec;
  logic [NTHR-1:0] rdy_vec;
  logic [PC_W-1:0] pc_all [NTHR];
  logic            pick_vld, pick_tid;

  for (genvar g = 0; g < NTHR; g++) begin : g_ctx
    localparam logic [31:0] RV = (g == 0) ? RESET_PC0 : RESET_PC1;
    logic miss_hit, pc_wr;
    assign miss_hit = miss_vld && (miss_tid == 1'(g));
    assign pc_wr    = pc_wr_en && pick_vld && (pick_tid == 1'(g));

    thr_wait_slot u_wait (
      .clk(clk), .rst_n(rst_n), .miss_hit(miss_hit),
      .fill(fill_vld[g]), .waiting_o(wait_vec[g]));

    thr_pc_slot #(.PC_W(PC_W), .RST_PC(RV)) u_pc (
      .clk(clk), .rst_n(rst_n), .wr(pc_wr),
      .wdata(pc_wr_data), .pc_o(pc_all[g]));

    assign rdy_vec[g] = thr_en[g] && !wait_vec[g];
  end

  thr_pick u_pick (
    .clk(clk), .rst_n(rst_n), .rdy(rdy_vec),
    .vld_o(pick_vld), .tid_o(pick_tid));

  assign issue_vld   = pick_vld;
  assign idle        = !pick_vld;
  assign sel_tid     = pick_tid;
  assign rf_bank_sel = pick_tid;
  assign sel_pc      = pc_all[pick_tid];

  // R4
  no_wait_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> (!wait_vec[sel_tid] && thr_en[sel_tid]));
  // R5
  all_wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&wait_vec) |-> (idle && !issue_vld));
  // R3
  switch_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && issue_vld && miss_tid == sel_tid)
      |=> !(issue_vld && sel_tid == $past(sel_tid)));
  // R8
  pc1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && sel_tid == 1'b0) |=> $stable(pc_all[1]));
  // R8
  pc0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && sel_tid == 1'b1) |=> $stable(pc_all[0]));
  // R8
  idle_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ($stable(pc_all[0]) && $stable(pc_all[1])));
endmodule

// File: tb/mt_thread_sel_bench.sv
`timescale 1ns/1ps
module mt_thread_sel_bench;
  localparam int          PC_W = 32;
  localparam logic [31:0] RV0  = 32'h0000_1000;
  localparam logic [31:0] RV1  = 32'h0000_2000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      thr_en = 2'b11;
  logic            miss_vld = 1'b0, miss_tid = 1'b0;
  logic [1:0]      fill_vld = 2'b00;
  logic            pc_wr_en = 1'b0;
  logic [PC_W-1:0] pc_wr_data = '0;
  logic            issue_vld, idle, sel_tid, rf_bank_sel;
  logic [PC_W-1:0] sel_pc;

  always #2.5 clk = ~clk;

  mt_thread_sel #(.PC_W(PC_W), .RESET_PC0(RV0), .RESET_PC1(RV1)) u_mt_thread_sel (
    .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .miss_vld(miss_vld),
    .miss_tid(miss_tid), .fill_vld(fill_vld), .pc_wr_en(pc_wr_en),
    .pc_wr_data(pc_wr_data), .issue_vld(issue_vld), .idle(idle),
    .sel_tid(sel_tid), .rf_bank_sel(rf_bank_sel), .sel_pc(sel_pc));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model of the requirements
  logic [1:0]      m_wait = 2'b00;
  logic            m_last = 1'b0, m_run = 1'b1;
  logic [PC_W-1:0] m_pc [2] = '{RV0, RV1};
  logic            e_vld, e_tid;

  function automatic logic [1:0] expect_sel(input logic [1:0] en, input logic [1:0] w,
                                            input logic last, input logic run);
    logic [1:0] ok;
    ok = en & ~w;
    if (run && ok[last])  return {1'b1, last};  // R7
    if (ok[~last])        return {1'b1, ~last}; // R3 / R6
    if (ok[last])         return {1'b1, last};
    return {1'b0, last};                         // R5
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // inputs already set at a negedge; compare, then advance one cycle
  task automatic step(input string tag);
    logic [1:0] e;
    #1;
    e = expect_sel(thr_en, m_wait, m_last, m_run);
    e_vld = e[1];
    e_tid = e[0];
    chk(tag, "issue_vld", 32'(issue_vld), 32'(e_vld));
    chk(tag, "idle", 32'(idle), 32'(!e_vld));
    if (e_vld) begin
      chk(tag, "sel_tid", 32'(sel_tid), 32'(e_tid));
      chk(tag, "sel_pc", sel_pc, m_pc[e_tid]);
      chk("R2", "rf_bank_sel", 32'(rf_bank_sel), 32'(sel_tid));
    end
    @(posedge clk);
    if (rst_n) begin
      if (pc_wr_en && e_vld) m_pc[e_tid] = pc_wr_data;
      for (int t = 0; t < 2; t++) begin
        if (miss_vld && miss_tid == 1'(t)) m_wait[t] = 1'b1;
        else if (fill_vld[t])              m_wait[t] = 1'b0;
      end
      m_run = e_vld;
      if (e_vld) m_last = e_tid;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    miss_vld = 1'b0; fill_vld = 2'b00; pc_wr_en = 1'b0; thr_en = 2'b11;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    step("R1");                                   // reset state while held
    rst_n = 1'b1;
    step("R1");                                   // right after release
    pc_wr_en = 1'b1; pc_wr_data = 32'h100; step("R8");
    quiet(); miss_vld = 1'b1; miss_tid = 1'b0; step("R3");
    quiet(); step("R3");                          // context 1 now issues
    pc_wr_en = 1'b1; pc_wr_data = 32'h200; step("R8");
    quiet(); miss_vld = 1'b1; miss_tid = 1'b1; step("R4");
    quiet(); pc_wr_en = 1'b1; pc_wr_data = 32'hdead; step("R5"); // ignored write
    quiet(); miss_vld = 1'b1; miss_tid = 1'b0; fill_vld = 2'b01; step("R10");
    quiet(); step("R10");                         // still both waiting
    fill_vld = 2'b11; step("R4");
    quiet(); step("R6");                          // picks context 0, PC 0x100
    fill_vld = 2'b01; step("R11");
    quiet(); step("R11");
    step("R7");
    thr_en = 2'b10; step("R9");
    quiet(); step("R7");
    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] e;
      quiet();
      e = expect_sel(thr_en, m_wait, m_last, m_run);
      if ($urandom % 20 == 0) thr_en = 2'($urandom);
      e = expect_sel(thr_en, m_wait, m_last, m_run);
      if (e[1] && $urandom % 6 == 0) begin
        miss_vld = 1'b1; miss_tid = e[0];
      end
      for (int t = 0; t < 2; t++)
        if (m_wait[t] && $urandom % 5 == 0) fill_vld[t] = 1'b1;
      pc_wr_en = 1'($urandom);
      pc_wr_data = $urandom;
      step(m_wait == 2'b11 ? "R5" : "R2");
    end
    quiet();
    step("R2");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule